// File: doc/BRIEF.md
# Manchester Bi-Phase-Level Line Encoder

This block converts a serial bit stream into a bi-phase-level line signal, together with its logical complement. The whole block runs synchronously on a clock at twice the bit rate, so every bit cell is two clock cycles long. A strobe input marks the cycle in which a new cell begins. On that edge the data bit is captured. The line then shows the bit's value for the first half-cell and its inverse for the second half-cell. As a result, a one appears as a falling edge in the middle of the cell and a zero as a rising edge in the middle of the cell.

There are two enables. A transmit-disable input turns off the output-enable flags of both line signals; a pad wrapper can use these flags to tri-state the lines. A clock-buffer enable gates a registered replica of the bit clock, which is high during the first half of each transmitted cell. An active-low reset is sampled on the clock edge and returns the encoder to idle. All outputs are registered.

Top module: `manchester_encoder`

## Requirements
- R1: A bit of value one, accepted on a clock edge, drives `line_p` high during the cycle after that edge and low during the cycle after that. This gives a high-to-low transition at mid-cell.
- R2: A bit of value zero, accepted on a clock edge, drives `line_p` low during the cycle after that edge and high during the cycle after that. This gives a low-to-high transition at mid-cell.
- R3: A bit is accepted only when `cell_stb` is high at an edge where the encoder is in the first half-cell phase. If `cell_stb` is high in the second half-cell, it is ignored. A change on `din` during the second half-cell does not affect the line.
- R4: While `rst_n` is high, `line_n` is always the logical inverse of `line_p`.
- R5: When `rst_n` is low at a clock edge, the following happens after that edge: `line_p` goes to the idle level (low by default), `line_n` goes high, `bclk_out` and all enable flags go low, the phase returns to first half-cell, and no bit is accepted.
- R6: When `rst_n` is high at an edge, the output-enable flags `line_p_oe` and `line_n_oe` take the inverse of `tx_dis` sampled at that edge. `tx_dis` has no effect on the line levels.
- R7: `bclk_oe` follows `clkbuf_en` registered. `bclk_out` is high for the first half of a cell only if `clkbuf_en` was high at the edge that accepted the bit. Otherwise `bclk_out` is low.
- R8: At a first-phase edge where no bit is accepted, `line_p` keeps its level and `bclk_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial data bit |
| cell_stb | input | 1 | Start-of-cell strobe |
| tx_dis | input | 1 | High disables both line outputs |
| clkbuf_en | input | 1 | Enables the bit-clock replica |
| line_p | output | 1 | True bi-phase line signal |
| line_n | output | 1 | Complementary line signal |
| line_p_oe | output | 1 | Output enable for `line_p` |
| line_n_oe | output | 1 | Output enable for `line_n` |
| bclk_out | output | 1 | Bit-clock replica, high in the first half-cell |
| bclk_oe | output | 1 | Output enable for the bit-clock replica |

## Verification
The properties assume that `cell_stb` marks the start of cells and that `din` is valid at the strobe edge. They also assume that all control inputs change only between clock edges. The stimulus drives every input on the falling clock edge and sweeps all 256 byte patterns, sent most significant bit first, as back-to-back cells. The enable inputs are derived from the pattern index. The stimulus also adds deliberately misplaced strobes in the second half-cell, data changes in the second half-cell, idle gaps, and a reset applied in mid-cell. These exercise the cases where inputs must be ignored.

// File: rtl/manchester_enc_pkg.sv
package manchester_enc_pkg;
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } cell_phase_e;

  localparam int unsigned NUM_LINES = 2;
endpackage

// File: rtl/mce_cell_seq.sv
module mce_cell_seq
  import manchester_enc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        din,
  input  logic        cell_stb,
  output cell_phase_e phase,
  output logic        take,
  output logic        level_load,
  output logic        next_level
);
  logic bit_q;

  assign take       = rst_n && cell_stb && (phase == PH_FIRST);
  assign level_load = take || (phase == PH_SECOND);
  assign next_level = take ? din : ~bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_FIRST;
      bit_q <= 1'b0;
    end else if (take) begin
      phase <= PH_SECOND;
      bit_q <= din;
    end else if (phase == PH_SECOND) begin
      phase <= PH_FIRST;
    end
  end
endmodule

// File: rtl/mce_line_drv.sv
module mce_line_drv #(
  parameter bit IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_load,
  input  logic next_level,
  output logic line_p,
  output logic line_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_p <= IDLE_LEVEL;
      line_n <= ~IDLE_LEVEL;
    end else if (level_load) begin
      line_p <= next_level;
      line_n <= ~next_level;
    end
  end
endmodule

// File: rtl/mce_enables.sv
module mce_enables
  import manchester_enc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 tx_dis,
  input  logic                 clkbuf_en,
  output logic [NUM_LINES-1:0] line_oe,
  output logic                 bclk_out,
  output logic                 bclk_oe
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line_oe
    always_ff @(posedge clk) begin
      if (!rst_n) line_oe[g] <= 1'b0;
      else        line_oe[g] <= ~tx_dis;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_out <= 1'b0;
      bclk_oe  <= 1'b0;
    end else begin
      bclk_out <= take && clkbuf_en;
      bclk_oe  <= clkbuf_en;
    end
  end
endmodule

// File: rtl/manchester_encoder.sv
module manchester_encoder
  import manchester_enc_pkg::*;
#(
  parameter bit IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic cell_stb,
  input  logic tx_dis,
  input  logic clkbuf_en,
  output logic line_p,
  output logic line_n,
  output logic line_p_oe,
  output logic line_n_oe,
  output logic bclk_out,
  output logic bclk_oe
);
  cell_phase_e          phase;
  logic                 cell_take;
  logic                 level_load;
  logic                 next_level;
  logic [NUM_LINES-1:0] line_oe;

  mce_cell_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (din),
    .cell_stb   (cell_stb),
    .phase      (phase),
    .take       (cell_take),
    .level_load (level_load),
    .next_level (next_level)
  );

  mce_line_drv #(.IDLE_LEVEL(IDLE_LEVEL)) u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_load (level_load),
    .next_level (next_level),
    .line_p     (line_p),
    .line_n     (line_n)
  );

  mce_enables u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (cell_take),
    .tx_dis    (tx_dis),
    .clkbuf_en (clkbuf_en),
    .line_oe   (line_oe),
    .bclk_out  (bclk_out),
    .bclk_oe   (bclk_oe)
  );

  assign line_p_oe = line_oe[0];
  assign line_n_oe = line_oe[1];
endmodule

// File: rtl/manchester_encoder_chk.sv
module manchester_encoder_chk #(
  parameter bit IDLE_LEVEL = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic din,
  input logic cell_stb,
  input logic tx_dis,
  input logic clkbuf_en,
  input logic cell_take,
  input logic line_p,
  input logic line_n,
  input logic line_p_oe,
  input logic line_n_oe,
  input logic bclk_out,
  input logic bclk_oe
);
  // R1 / R2: first half-cell carries the captured bit
  p_first_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cell_take |=> (line_p == $past(din)));

  // R1 / R2: second half-cell inverts it (mid-cell transition)
  p_mid_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cell_take ##1 rst_n |=> (line_p == ~$past(line_p)));

  // R3: no acceptance in the second half-cell
  p_one_per_cell_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cell_take |=> !cell_take);

  // R4: complement output
  p_complement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (line_n == ~line_p));

  // R5: reset idle state
  p_reset_idle_r5: assert property (@(posedge clk)
    !rst_n |=> (line_p == IDLE_LEVEL) && line_n == ~IDLE_LEVEL && !bclk_out && !line_p_oe && !line_n_oe && !bclk_oe);

  // R6: transmit disable
  p_tx_disable_r6: assert property (@(posedge clk)
    (rst_n && tx_dis) |=> (!line_p_oe && !line_n_oe));

  // R7: replica gated by its enable
  p_bclk_gate_r7: assert property (@(posedge clk)
    (rst_n && !clkbuf_en) |=> (!bclk_out && !bclk_oe));

  // R8: idle hold
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cell_take && !$past(cell_take) && $past(rst_n)) |=> $stable(line_p) && !bclk_out);
endmodule

bind manchester_encoder manchester_encoder_chk #(.IDLE_LEVEL(IDLE_LEVEL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din       (din),
  .cell_stb  (cell_stb),
  .tx_dis    (tx_dis),
  .clkbuf_en (clkbuf_en),
  .cell_take (cell_take),
  .line_p    (line_p),
  .line_n    (line_n),
  .line_p_oe (line_p_oe),
  .line_n_oe (line_n_oe),
  .bclk_out  (bclk_out),
  .bclk_oe   (bclk_oe)
);

// File: tb/manchester_encoder_tb.sv
module manchester_encoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic cell_stb = 1'b0;
  logic tx_dis = 1'b0;
  logic clkbuf_en = 1'b0;
  logic line_p, line_n, line_p_oe, line_n_oe, bclk_out, bclk_oe;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  manchester_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .cell_stb(cell_stb),
    .tx_dis(tx_dis), .clkbuf_en(clkbuf_en),
    .line_p(line_p), .line_n(line_n), .line_p_oe(line_p_oe),
    .line_n_oe(line_n_oe), .bclk_out(bclk_out), .bclk_oe(bclk_oe)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] pack_out();
    return {line_p, line_n, line_p_oe, line_n_oe, bclk_out, bclk_oe};
  endfunction

  // One cell: strobe + bit in first half; second half drives junk on din
  // and optionally a stray strobe (R3).
  task automatic send_bit(input logic d, input logic en, input logic dis, input logic stray);
    @(negedge clk);
    cell_stb = 1'b1; din = d; clkbuf_en = en; tx_dis = dis;
    @(posedge clk); #1;
    // R1 R2 R6 R7: first half shows the bit, replica high when enabled
    chk(d ? "R1" : "R2", pack_out(), {d, ~d, ~dis, ~dis, en, en});
    @(negedge clk);
    cell_stb = stray; din = ~d;
    @(posedge clk); #1;
    // R1 R2 R3 R4: second half shows the inverse, din change ignored
    chk(stray ? "R3" : (d ? "R1" : "R2"), pack_out(), {~d, d, ~dis, ~dis, 1'b0, en});
  endtask

  initial begin
    // R5: reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R5", pack_out(), 6'b010000);
    @(negedge clk); rst_n = 1'b1;

    // Exhaustive byte sweep, MSB first, back-to-back cells
    for (int p = 0; p < 256; p++) begin
      for (int b = 7; b >= 0; b--) begin
        send_bit(p[b], p[0] ^ p[3], p[1] & p[2], 1'b0);
      end
    end

    // R3: stray strobe in second half is ignored, then R8 idle hold
    send_bit(1'b1, 1'b1, 1'b0, 1'b1);
    @(negedge clk); cell_stb = 1'b0; din = 1'b1;
    @(posedge clk); #1;
    chk("R8", pack_out(), 6'b011101);
    @(negedge clk);
    @(posedge clk); #1;
    chk("R8", pack_out(), 6'b011101);
    send_bit(1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk); cell_stb = 1'b0;
    @(posedge clk); #1;
    chk("R8", pack_out(), 6'b100000);

    // R5: reset in mid-cell, strobes ignored while held
    @(negedge clk); cell_stb = 1'b1; din = 1'b1; tx_dis = 1'b0; clkbuf_en = 1'b1;
    @(posedge clk); #1;
    chk("R1", pack_out(), 6'b101111);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R5", pack_out(), 6'b010000);
    @(negedge clk); din = 1'b1;
    @(posedge clk); #1;
    chk("R5", pack_out(), 6'b010000);
    @(negedge clk); rst_n = 1'b1; cell_stb = 1'b0;
    // R5: phase cleared, first strobe after release is accepted
    send_bit(1'b1, 1'b1, 1'b0, 1'b0);
    send_bit(1'b0, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule